// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Reader

This block is the read side of a one-bit-wide configuration store that feeds a programmable logic device loading itself in master serial mode. The device's configuration clock steps an internal address counter, and each clock presents the next stored bit on a tri-state data line. The line is modelled as a value plus a separate drive-enable, so a wrapper can form the shared wire. The bits come out in ascending address order.

Several instances can be chained. Each one's active-low chain-enable output feeds the chip enable of the next. When the last location of one store has been consumed, it releases the data line, and the next store in the chain takes over on the following clock. A combined reset/output-enable pin clears the counter; a configuration input selects which level of that pin means reset. A serial-enable pin switches the block into programming mode, which shuts off the whole read path. After power-up a ready flag is held low for a fixed number of clocks.

The array depth is a parameter; a full-size store uses a depth of 1048576. A synchronous write port loads the array.

Top module: `cfg_stream_reader`

## Requirements
- R1: While reading is enabled, the block presents the bit at address 0 first. Each rising clock edge then moves to the next address, so bits leave in ascending address order, one per clock.
- R2: When the reset level is applied to `rst_oe` and `ser_en` is high, `dout_oe` is low at once. The next clock edge clears the address counter and the drained state, whatever `ce_n` is.
- R3: While `ser_en` is high and `ce_n` is high, `standby` is 1 and `dout_oe` is 0. Clock edges leave the address counter unchanged.
- R4: With `pol_sel` = 0, `rst_oe` low means reset and `rst_oe` high means output enabled. With `pol_sel` = 1, the meaning of the two levels is swapped.
- R5: On the clock edge that consumes the last location (address DEPTH-1), the block enters the drained state. From then on `dout_oe` is 0, and `ceo_n` is low while `ce_n` is low and the output is enabled.
- R6: Once drained, `ceo_n` follows `ce_n` until `rst_oe` takes its reset level. It then stays high, even after reading resumes, until the whole array has been read again.
- R7: While `por_n` is low, and for PWRUP_CYC clock edges after it rises, `ready` is 0, `dout_oe` is 0, `ceo_n` is 1 and the counter is held at 0. After that, `ready` stays 1.
- R8: While `ser_en` is low, `dout_oe` is 0, `ceo_n` is 1 and `standby` is 0. The counter and the drained state hold, and the reset level on `rst_oe` is ignored.
- R9: When two instances are chained (`ceo_n` of the first to `ce_n` of the second), the second drives its address-0 bit in the clock cycle right after the one in which the first drove its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; counter steps on the rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined reset / output-enable pin, meaning set by `pol_sel` |
| ser_en | input | 1 | High for read mode, low for programming mode |
| pol_sel | input | 1 | 0: `rst_oe` low resets; 1: `rst_oe` high resets |
| wr_en | input | 1 | Array write strobe, sampled on the rising edge |
| wr_addr | input | AW | Array write address (AW = clog2(DEPTH)) |
| wr_data | input | 1 | Array write bit |
| dout | output | 1 | Data value, 0 when not driven |
| dout_oe | output | 1 | Drive enable of the data line |
| ceo_n | output | 1 | Chain enable to the next device, active low |
| standby | output | 1 | High while in read mode with chip enable high |
| ready | output | 1 | Low during the power-up interval |

## Verification
The hardest point to reach is the handover between chained stores. The first store must have read its entire array, with no reset or chip-enable glitch on the way, before its chain output falls. The bench therefore makes both arrays short and loads two distinct bit patterns. It then runs one unbroken enabled stream through both stores while a scoreboard pops the expected concatenation and flags any cycle in which neither or both drive. The sticky chain output and the frozen counter in programming mode are then reached from that drained state, by toggling chip enable and reset and by entering programming mode partway through a second read.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    // Meaning of the pol_sel configuration bit
    typedef enum logic {
        POL_RST_LOW  = 1'b0,
        POL_RST_HIGH = 1'b1
    } rst_pol_e;

    // Read phase of one store
    typedef enum logic {
        PH_STREAM  = 1'b0,
        PH_DRAINED = 1'b1
    } phase_e;

    // True when the combined pin sits at its reset level
    function automatic logic reset_asserted(input logic pol, input logic pin);
        return (rst_pol_e'(pol) == POL_RST_HIGH) ? pin : ~pin;
    endfunction

endpackage

// File: rtl/cfg_powerup.sv
module cfg_powerup #(
    parameter int PWRUP_CYC = 8
) (
    input  logic clk,
    input  logic por_n,
    output logic ready
);
    localparam int CW = $clog2(PWRUP_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(PWRUP_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } pwr_t;

    pwr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.rdy) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST_CNT) begin
                s_d.rdy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready = s_q.rdy;

endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
    import cfg_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          hold_zero,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] addr,
    output phase_e        phase
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        phase_e        phase;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hold_zero || clr) begin
            s_d.addr  = '0;
            s_d.phase = PH_STREAM;
        end else if (step) begin
            if (s_q.addr == LAST) begin
                s_d.addr  = '0;
                s_d.phase = PH_DRAINED;
            end else begin
                s_d.addr = s_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '{addr: '0, phase: PH_STREAM};
        end else begin
            s_q <= s_d;
        end
    end

    assign addr  = s_q.addr;
    assign phase = s_q.phase;

endmodule

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr <= TOP)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (raddr <= TOP) ? mem[raddr] : 1'b0;

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfg_pkg::*;
#(
    parameter  int DEPTH     = 2048,
    parameter  int PWRUP_CYC = 8,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          ce_n,
    input  logic          rst_oe,
    input  logic          ser_en,
    input  logic          pol_sel,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_data,
    output logic          dout,
    output logic          dout_oe,
    output logic          ceo_n,
    output logic          standby,
    output logic          ready
);
    logic [AW-1:0] addr_q;
    phase_e        phase_q;
    logic          cur_bit;

    typedef struct packed {
        logic rst_lvl;
        logic run;
        logic clr;
        logic rd_en;
        logic chain_lo;
    } ctl_t;

    ctl_t ctl;

    always_comb begin
        ctl.rst_lvl  = reset_asserted(pol_sel, rst_oe);
        ctl.run      = ser_en & ready;
        ctl.clr      = ctl.run & ctl.rst_lvl;
        ctl.rd_en    = ctl.run & ~ce_n & ~ctl.rst_lvl & (phase_q == PH_STREAM);
        ctl.chain_lo = ctl.run & ~ce_n & ~ctl.rst_lvl & (phase_q == PH_DRAINED);
    end

    cfg_powerup #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
        .clk   (clk),
        .por_n (por_n),
        .ready (ready)
    );

    cfg_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
        .clk       (clk),
        .por_n     (por_n),
        .hold_zero (~ready),
        .clr       (ctl.clr),
        .step      (ctl.rd_en),
        .addr      (addr_q),
        .phase     (phase_q)
    );

    cfg_bit_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (addr_q),
        .rdata (cur_bit)
    );

    assign dout_oe = ctl.rd_en;
    assign dout    = ctl.rd_en & cur_bit;
    assign ceo_n   = ~ctl.chain_lo;
    assign standby = ser_en & ce_n;

endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk
    import cfg_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          por_n,
    input logic          ce_n,
    input logic          rst_oe,
    input logic          ser_en,
    input logic          pol_sel,
    input logic          dout_oe,
    input logic          ceo_n,
    input logic          standby,
    input logic          ready,
    input logic [AW-1:0] addr_q,
    input phase_e        phase_q
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic rst_lvl;
    assign rst_lvl = pol_sel ? rst_oe : ~rst_oe;

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!por_n)
        (dout_oe && addr_q != LAST) |=> (addr_q == $past(addr_q) + 1'b1)); // R1

    AST_RESET_TRISTATES: assert property (@(posedge clk) disable iff (!por_n)
        (ser_en && rst_lvl) |-> !dout_oe); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (ready && ser_en && rst_lvl) |=> (addr_q == '0 && phase_q == PH_STREAM)); // R2

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        (ser_en && ce_n) |-> (standby && !dout_oe)); // R3

    AST_CE_FREEZES: assert property (@(posedge clk) disable iff (!por_n)
        (ready && ser_en && ce_n && !rst_lvl) |=> $stable(addr_q)); // R3

    AST_LAST_DRAINS: assert property (@(posedge clk) disable iff (!por_n)
        (dout_oe && addr_q == LAST) |=> (phase_q == PH_DRAINED && !dout_oe)); // R5

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!por_n)
        !ceo_n |-> !dout_oe); // R5

    AST_CHAIN_NEEDS_CE: assert property (@(posedge clk) disable iff (!por_n)
        ce_n |-> ceo_n); // R6

    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        !ready |-> (!dout_oe && ceo_n && addr_q == '0)); // R7

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!por_n)
        ready |=> ready); // R7

    AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        !ser_en |-> (!dout_oe && ceo_n && !standby)); // R8

    AST_PROG_FREEZES: assert property (@(posedge clk) disable iff (!por_n)
        (ready && !ser_en) |=> ($stable(addr_q) && $stable(phase_q))); // R8

endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .ce_n    (ce_n),
    .rst_oe  (rst_oe),
    .ser_en  (ser_en),
    .pol_sel (pol_sel),
    .dout_oe (dout_oe),
    .ceo_n   (ceo_n),
    .standby (standby),
    .ready   (ready),
    .addr_q  (addr_q),
    .phase_q (phase_q)
);

// File: tb/cfg_stream_reader_test.sv
module cfg_stream_reader_test;
    localparam int DEPTH = 16;
    localparam int PWR   = 4;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [15:0] PAT0 = 16'hB4D3;
    localparam logic [15:0] PAT1 = 16'h2F69;

    logic clk = 1'b0;
    logic por_n = 1'b0, ce0_n = 1'b1, rst_oe = 1'b1, ser_en = 1'b1, pol_sel = 1'b0;
    logic wr_en = 1'b0, wd0 = 1'b0, wd1 = 1'b0;
    logic [AW-1:0] wa = '0;
    logic dout0, oe0, ceo0_n, sb0, rdy0;
    logic dout1, oe1, ceo1_n, sb1, rdy1;

    int checks = 0;
    int fails  = 0;
    logic sb_on = 1'b0;
    logic exp_q [$];

    always #4 clk = ~clk;

    cfg_stream_reader #(.DEPTH(DEPTH), .PWRUP_CYC(PWR)) uut (
        .clk(clk), .por_n(por_n), .ce_n(ce0_n), .rst_oe(rst_oe), .ser_en(ser_en),
        .pol_sel(pol_sel), .wr_en(wr_en), .wr_addr(wa), .wr_data(wd0),
        .dout(dout0), .dout_oe(oe0), .ceo_n(ceo0_n), .standby(sb0), .ready(rdy0));

    cfg_stream_reader #(.DEPTH(DEPTH), .PWRUP_CYC(PWR)) uut_next (
        .clk(clk), .por_n(por_n), .ce_n(ceo0_n), .rst_oe(rst_oe), .ser_en(ser_en),
        .pol_sel(pol_sel), .wr_en(wr_en), .wr_addr(wa), .wr_data(wd1),
        .dout(dout1), .dout_oe(oe1), .ceo_n(ceo1_n), .standby(sb1), .ready(rdy1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        #2;
    endtask

    // driver: expected stream = first array then second array
    task automatic push_stream();
        for (int i = 0; i < DEPTH; i++) exp_q.push_back(PAT0[i]);
        for (int i = 0; i < DEPTH; i++) exp_q.push_back(PAT1[i]);
    endtask

    // monitor: scoreboard on the shared line
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb_on) begin
                if (oe0 && oe1) begin
                    check("R9 both driving", 32'd1, 32'd0);
                end else if (oe0 || oe1) begin
                    if (exp_q.size() == 0) begin
                        check("R1 extra bit", 32'd1, 32'd0);
                    end else begin
                        check("R1 stream bit", {31'd0, oe0 ? dout0 : dout1}, {31'd0, exp_q.pop_front()});
                    end
                end else begin
                    check("R9 idle gap", 32'd0, 32'd1);
                end
            end
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        int n;
        // R7 power-up
        nxt(); nxt(); #1;
        check("R7 ready low", {31'd0, rdy0}, 32'd0);
        check("R7 no drive", {31'd0, oe0}, 32'd0);
        check("R7 chain high", {31'd0, ceo0_n}, 32'd1);
        nxt(); por_n = 1'b1;
        n = 0;
        while (!rdy0 && n < 100) begin nxt(); #1; n++; end
        check("R7 ready delay", n, PWR);
        // load both arrays
        for (int i = 0; i < DEPTH; i++) begin
            nxt(); wr_en = 1'b1; wa = AW'(i); wd0 = PAT0[i]; wd1 = PAT1[i];
        end
        nxt(); wr_en = 1'b0;
        // R2: reset level with chip enable low
        nxt(); ce0_n = 1'b0; rst_oe = 1'b0; #1;
        check("R2 tristate in reset", {31'd0, oe0}, 32'd0);
        // R3: standby, counter frozen
        nxt(); ce0_n = 1'b1; rst_oe = 1'b1; #1;
        check("R3 standby", {31'd0, sb0}, 32'd1);
        check("R3 no drive", {31'd0, oe0}, 32'd0);
        nxt(); nxt();
        // R1/R9 full chained stream
        push_stream(); ce0_n = 1'b0; sb_on = 1'b1;
        for (int i = 1; i < 2 * DEPTH; i++) begin
            nxt();
            if (i == DEPTH) begin
                #1;
                check("R9 next drives", {31'd0, oe1}, 32'd1);
                check("R5 first released", {31'd0, oe0}, 32'd0);
                check("R5 chain low", {31'd0, ceo0_n}, 32'd0);
            end
        end
        nxt(); sb_on = 1'b0; #1;
        check("R1 queue drained", exp_q.size(), 32'd0);
        check("R5 second released", {31'd0, oe1}, 32'd0);
        check("R5 second chain low", {31'd0, ceo1_n}, 32'd0);
        // R6 chain output sequence
        nxt(); ce0_n = 1'b1; #1;
        check("R6 follows ce high", {31'd0, ceo0_n}, 32'd1);
        nxt(); ce0_n = 1'b0; #1;
        check("R6 follows ce low", {31'd0, ceo0_n}, 32'd0);
        check("R5 drained no drive", {31'd0, oe0}, 32'd0);
        nxt(); rst_oe = 1'b0; #1;
        check("R6 high on reset", {31'd0, ceo0_n}, 32'd1);
        nxt(); rst_oe = 1'b1; #1;
        check("R6 stays high", {31'd0, ceo0_n}, 32'd1);
        check("R2 restart drive", {31'd0, oe0}, 32'd1);
        check("R2 restart bit0", {31'd0, dout0}, {31'd0, PAT0[0]});
        nxt(); #1; check("R1 bit1", {31'd0, dout0}, {31'd0, PAT0[1]});
        nxt(); #1; check("R1 bit2", {31'd0, dout0}, {31'd0, PAT0[2]});
        // R8 programming mode mid-read
        nxt(); ser_en = 1'b0; #1;
        check("R8 no drive", {31'd0, oe0}, 32'd0);
        check("R8 chain high", {31'd0, ceo0_n}, 32'd1);
        check("R8 no standby", {31'd0, sb1}, 32'd0);
        nxt(); rst_oe = 1'b0; #1;
        check("R8 no drive in reset", {31'd0, oe0}, 32'd0);
        nxt(); rst_oe = 1'b1;
        nxt(); ser_en = 1'b1; #1;
        check("R8 resume drive", {31'd0, oe0}, 32'd1);
        check("R8 resume bit3", {31'd0, dout0}, {31'd0, PAT0[3]});
        // R4 inverted polarity
        nxt(); pol_sel = 1'b1; rst_oe = 1'b1; #1;
        check("R4 high is reset", {31'd0, oe0}, 32'd0);
        nxt(); rst_oe = 1'b0; #1;
        check("R4 low enables", {31'd0, oe0}, 32'd1);
        check("R4 restart bit0", {31'd0, dout0}, {31'd0, PAT0[0]});
        nxt(); #1; check("R4 bit1", {31'd0, dout0}, {31'd0, PAT0[1]});
        summary();
        $finish;
    end

endmodule